// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital control for a dual-slope integrating analog-to-digital converter. The input clock is divided down to a count tick. On each tick the block moves through four phases in a fixed order: integrator discharge, offset nulling, signal integration and reference de-integration. It raises one phase-enable output for whichever phase is active, so that the analog switches around an external integrator can follow it. At the end of signal integration it samples the comparator to find the input polarity, and it uses that polarity to choose the reference sign for de-integration. It then counts ticks until the comparator reports that the integrator has crossed zero. That count is the reading.

The discharge phase takes up whatever de-integration time was not used, so a conversion always lasts the same number of ticks for a given range setting. After each conversion the end-of-conversion line drops low for a fixed number of clocks. On the first of those clocks the result is loaded into a display register, unless the hold input forbids the load. With peak-hold on, the load is also skipped unless the new magnitude is larger than the one shown. The display register is presented both as a binary count and as packed decimal digits, together with a sign bit and over- and underrange flags.

Top module: `dsadc_seq`

## Requirements
- R1: After a synchronous active-low reset, the discharge phase enable is high and the other three enables are low. The end-of-conversion line is high, the displayed count is 0 with positive sign, the overrange flag is 0 and the underrange flag is 1.
- R2: Exactly one phase enable is high at any time. Phases advance only in the order discharge, nulling, integrate, de-integrate, then back to discharge. The nulling phase lasts AZ_COUNTS ticks, and one tick is CLK_DIV (default 2) input clocks.
- R3: The integrate phase lasts INT_COUNTS ticks. It lasts INT_COUNTS/RANGE_DIV ticks when range_hi_i is high at the last tick of the nulling phase.
- R4: Measured from one nulling-phase start to the next, a conversion lasts AZ_COUNTS + INTEGRATE + (FULL_SCALE+2) + ZI_BASE ticks whatever the reading, where INTEGRATE is the length given in R3. The discharge phase lasts ZI_BASE plus the unused de-integrate ticks.
- R5: cmp_i is sampled on the last integrate tick. ref_neg_o is high throughout de-integration exactly when that sample was 1, and is low outside de-integration. The displayed sign rd_neg_o is the inverse of that sample.
- R6: The reading is the number of de-integrate ticks that complete before the tick at which cmp_i is first seen different from the latched polarity, so a flip seen on the first tick gives 0. rd_bcd_o holds the displayed count as 4-bit decimal digits, with units in bits [3:0] and each more significant digit 4 bits higher.
- R7: If cmp_i has not flipped after FULL_SCALE+2 de-integrate ticks, the phase ends and the reading is FULL_SCALE+2. ovr_o is high exactly when the displayed count exceeds FULL_SCALE (default 3999).
- R8: udr_o is high exactly when the displayed count is at most UR_LIMIT (default 380).
- R9: eoc_n_o goes low on the clock after de-integration ends and stays low for exactly EOC_CLKS (default 10) clocks. The display register takes its new value on the edge at which eoc_n_o falls.
- R10: While hold_i is high, conversions keep running but the display register does not change. Once hold_i is low, the next conversion loads normally.
- R11: While peak_hold_i is high, the display register loads only when the new count is strictly greater than the displayed count, and the sign is ignored in that comparison. An equal or smaller count leaves both count and sign unchanged. After peak_hold_i goes low, normal loading resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_i | input | 1 | Integrator comparator output |
| range_hi_i | input | 1 | Shortens the integrate phase by RANGE_DIV |
| hold_i | input | 1 | Freezes the display register |
| peak_hold_i | input | 1 | Loads only larger magnitudes |
| ph_zero_o | output | 1 | Integrator discharge phase enable |
| ph_az_o | output | 1 | Offset-nulling phase enable |
| ph_int_o | output | 1 | Signal integrate phase enable |
| ph_deint_o | output | 1 | Reference de-integrate phase enable |
| ref_neg_o | output | 1 | Selects the negative reference during de-integration |
| eoc_n_o | output | 1 | End-of-conversion strobe, active low |
| rd_bin_o | output | $clog2(FULL_SCALE+3) | Displayed count, binary |
| rd_bcd_o | output | 4*DIGITS | Displayed count, packed decimal |
| rd_neg_o | output | 1 | Displayed sign, 1 = negative |
| ovr_o | output | 1 | Displayed count above full scale |
| udr_o | output | 1 | Displayed count at or below the underrange limit |

## Verification
Conversions are run with comparator flips placed at chosen tick offsets. These include zero, values next to the underrange limit, values next to full scale, and no flip at all. Together they separate an off-by-one in the reading count from a wrong flag threshold and from a failed timeout. Each polarity is run once and both range settings are used, so that the sign latch and the reference select can be told apart from the integrate-length choice. Nulling-start to nulling-start intervals are measured across short, long and timed-out readings, which shows whether the discharge phase really takes up the unused de-integrate time. Hold and peak-hold runs feed in readings that are larger, smaller and equal to the one shown, plus one larger reading of opposite sign. These runs separate a magnitude comparison from a signed comparison or a greater-or-equal one.

// File: rtl/dsadc_seq_pkg.sv
package dsadc_seq_pkg;

  typedef enum logic [1:0] {
    PH_ZERO  = 2'd0,
    PH_AZ    = 2'd1,
    PH_INT   = 2'd2,
    PH_DEINT = 2'd3
  } phase_e;

  // Ticks left for the discharge phase once de-integration used 'used' ticks.
  function automatic int unsigned zero_len(input int unsigned base,
                                           input int unsigned dmax,
                                           input int unsigned used);
    return base + dmax - used;
  endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int CLK_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick_o = (div_q == LAST);
endmodule

// File: rtl/adc_phase_ctrl.sv
module adc_phase_ctrl
  import dsadc_seq_pkg::*;
#(
  parameter int AZ_COUNTS  = 1500,
  parameter int INT_COUNTS = 2000,
  parameter int RANGE_DIV  = 10,
  parameter int DEINT_MAX  = 4001,
  parameter int ZI_BASE    = 499,
  parameter int CW         = 14,
  parameter int RW         = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          cmp_i,
  input  logic          range_hi_i,
  output phase_e        phase_o,
  output logic          pol_o,
  output logic          done_o,
  output logic [RW-1:0] result_o
);
  localparam int INT_SHORT = INT_COUNTS / RANGE_DIV;
  localparam logic [CW-1:0] AZ_LAST    = CW'(AZ_COUNTS - 1);
  localparam logic [CW-1:0] INT_LAST_L = CW'(INT_COUNTS - 1);
  localparam logic [CW-1:0] INT_LAST_S = CW'(INT_SHORT - 1);
  localparam logic [CW-1:0] DEI_LAST   = CW'(DEINT_MAX - 1);
  localparam logic [CW-1:0] ZI_TOP     = CW'(zero_len(ZI_BASE, DEINT_MAX, 1));

  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] zi_len_q;
  logic          range_q;
  logic          pol_q;
  logic          done_q;
  logic [RW-1:0] result_q;

  logic [CW-1:0] int_last;
  logic          crossed;
  logic          ph_end;

  assign int_last = range_q ? INT_LAST_S : INT_LAST_L;
  assign crossed  = (cmp_i != pol_q);

  always_comb begin
    unique case (phase_q)
      PH_ZERO:  ph_end = (cnt_q == zi_len_q - 1'b1);
      PH_AZ:    ph_end = (cnt_q == AZ_LAST);
      PH_INT:   ph_end = (cnt_q == int_last);
      PH_DEINT: ph_end = crossed || (cnt_q == DEI_LAST);
      default:  ph_end = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_ZERO;
      cnt_q    <= '0;
      zi_len_q <= CW'(ZI_BASE);
      range_q  <= 1'b0;
      pol_q    <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (tick_i) begin
        if (!ph_end) begin
          cnt_q <= cnt_q + 1'b1;
        end else begin
          cnt_q <= '0;
          unique case (phase_q)
            PH_ZERO: phase_q <= PH_AZ;
            PH_AZ: begin
              phase_q <= PH_INT;
              range_q <= range_hi_i;
            end
            PH_INT: begin
              phase_q <= PH_DEINT;
              pol_q   <= cmp_i;
            end
            default: begin
              phase_q <= PH_ZERO;
              done_q  <= 1'b1;
              if (crossed) begin
                result_q <= cnt_q[RW-1:0];
                zi_len_q <= ZI_TOP - cnt_q;
              end else begin
                result_q <= RW'(DEINT_MAX);
                zi_len_q <= CW'(ZI_BASE);
              end
            end
          endcase
        end
      end
    end
  end

  assign phase_o  = phase_q;
  assign pol_o    = pol_q;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/adc_disp_reg.sv
module adc_disp_reg #(
  parameter int RW       = 12,
  parameter int DIGITS   = 4,
  parameter int EOC_CLKS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [RW-1:0]     result_i,
  input  logic              pol_i,
  input  logic              hold_i,
  input  logic              peak_i,
  output logic              eoc_n_o,
  output logic [RW-1:0]     disp_o,
  output logic [4*DIGITS-1:0] bcd_o,
  output logic              neg_o
);
  localparam int EW = $clog2(EOC_CLKS + 1);

  logic [EW-1:0] eoc_cnt_q;
  logic [RW-1:0] disp_q;
  logic          neg_q;
  logic          load;

  function automatic logic [4*DIGITS-1:0] to_bcd(input logic [RW-1:0] b);
    logic [4*DIGITS-1:0] r;
    r = '0;
    for (int i = RW - 1; i >= 0; i--) begin
      for (int d = 0; d < DIGITS; d++) begin
        if (r[4*d +: 4] >= 4'd5) r[4*d +: 4] = r[4*d +: 4] + 4'd3;
      end
      r = {r[4*DIGITS-2:0], b[i]};
    end
    return r;
  endfunction

  function automatic logic accept(input logic h, input logic pk,
                                  input logic [RW-1:0] nw,
                                  input logic [RW-1:0] cur);
    return !h && (!pk || (nw > cur));
  endfunction

  assign load = done_i && accept(hold_i, peak_i, result_i, disp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eoc_cnt_q <= '0;
      disp_q    <= '0;
      neg_q     <= 1'b0;
    end else begin
      if (done_i)                eoc_cnt_q <= EW'(EOC_CLKS);
      else if (eoc_cnt_q != '0)  eoc_cnt_q <= eoc_cnt_q - 1'b1;
      if (load) begin
        disp_q <= result_i;
        neg_q  <= ~pol_i;
      end
    end
  end

  assign eoc_n_o = (eoc_cnt_q == '0);
  assign disp_o  = disp_q;
  assign neg_o   = neg_q;
  assign bcd_o   = to_bcd(disp_q);
endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_seq_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int AZ_COUNTS  = 1500,
  parameter int INT_COUNTS = 2000,
  parameter int RANGE_DIV  = 10,
  parameter int FULL_SCALE = 3999,
  parameter int UR_LIMIT   = 380,
  parameter int ZI_BASE    = 499,
  parameter int EOC_CLKS   = 10,
  parameter int DIGITS     = 4,
  localparam int DEINT_MAX = FULL_SCALE + 2,
  localparam int RW        = $clog2(DEINT_MAX + 1),
  localparam int CW        = $clog2(ZI_BASE + DEINT_MAX + AZ_COUNTS + INT_COUNTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmp_i,
  input  logic                range_hi_i,
  input  logic                hold_i,
  input  logic                peak_hold_i,
  output logic                ph_zero_o,
  output logic                ph_az_o,
  output logic                ph_int_o,
  output logic                ph_deint_o,
  output logic                ref_neg_o,
  output logic                eoc_n_o,
  output logic [RW-1:0]       rd_bin_o,
  output logic [4*DIGITS-1:0] rd_bcd_o,
  output logic                rd_neg_o,
  output logic                ovr_o,
  output logic                udr_o
);
  logic          tick;
  phase_e        phase;
  logic          pol;
  logic          conv_done;
  logic [RW-1:0] conv_result;

  adc_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  adc_phase_ctrl #(
    .AZ_COUNTS(AZ_COUNTS), .INT_COUNTS(INT_COUNTS), .RANGE_DIV(RANGE_DIV),
    .DEINT_MAX(DEINT_MAX), .ZI_BASE(ZI_BASE), .CW(CW), .RW(RW)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cmp_i(cmp_i),
    .range_hi_i(range_hi_i), .phase_o(phase), .pol_o(pol),
    .done_o(conv_done), .result_o(conv_result)
  );

  adc_disp_reg #(.RW(RW), .DIGITS(DIGITS), .EOC_CLKS(EOC_CLKS)) u_disp (
    .clk(clk), .rst_n(rst_n), .done_i(conv_done), .result_i(conv_result),
    .pol_i(pol), .hold_i(hold_i), .peak_i(peak_hold_i),
    .eoc_n_o(eoc_n_o), .disp_o(rd_bin_o), .bcd_o(rd_bcd_o), .neg_o(rd_neg_o)
  );

  assign ph_zero_o  = (phase == PH_ZERO);
  assign ph_az_o    = (phase == PH_AZ);
  assign ph_int_o   = (phase == PH_INT);
  assign ph_deint_o = (phase == PH_DEINT);
  assign ref_neg_o  = ph_deint_o && pol;

  assign ovr_o = (rd_bin_o > RW'(FULL_SCALE));
  assign udr_o = (rd_bin_o <= RW'(UR_LIMIT));
endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int RW       = 12,
  parameter int EOC_CLKS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_i,
  input logic          peak_hold_i,
  input logic          ph_zero_o,
  input logic          ph_az_o,
  input logic          ph_int_o,
  input logic          ph_deint_o,
  input logic          ref_neg_o,
  input logic          eoc_n_o,
  input logic [RW-1:0] rd_bin_o
);
  localparam int LW = $clog2(EOC_CLKS + 2);
  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        low_cnt <= '0;
    else if (!eoc_n_o) low_cnt <= low_cnt + 1'b1;
    else               low_cnt <= '0;
  end

  p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ph_zero_o, ph_az_o, ph_int_o, ph_deint_o}) == 1);
  p_az_after_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_az_o) |-> $past(ph_zero_o));
  p_int_after_az_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_int_o) |-> $past(ph_az_o));
  p_deint_after_int_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ph_deint_o) |-> $past(ph_int_o));
  p_ref_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_deint_o && $past(ph_deint_o)) |-> $stable(ref_neg_o));
  p_ref_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ph_deint_o |-> !ref_neg_o);
  p_eoc_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_n_o) |-> (ph_zero_o && $past(ph_deint_o, 2)));
  p_eoc_short_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc_n_o |-> (low_cnt < LW'(EOC_CLKS)));
  p_eoc_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc_n_o) |-> (low_cnt == LW'(EOC_CLKS)));
  p_hold_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(rd_bin_o));
  p_peak_rises_r11: assert property (@(posedge clk) disable iff (!rst_n)
    peak_hold_i |=> (rd_bin_o >= $past(rd_bin_o)));
endmodule

bind dsadc_seq dsadc_seq_chk #(.RW(RW), .EOC_CLKS(EOC_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .peak_hold_i(peak_hold_i),
  .ph_zero_o(ph_zero_o), .ph_az_o(ph_az_o), .ph_int_o(ph_int_o),
  .ph_deint_o(ph_deint_o), .ref_neg_o(ref_neg_o), .eoc_n_o(eoc_n_o),
  .rd_bin_o(rd_bin_o)
);

// File: tb/dsadc_seq_tb.sv
module dsadc_seq_tb;
  localparam int AZ   = 20;
  localparam int INTC = 40;
  localparam int RDIV = 10;
  localparam int FS   = 99;
  localparam int UR   = 9;
  localparam int ZB   = 10;
  localparam int EOCC = 10;
  localparam int DMAX = FS + 2;
  localparam int RW   = $clog2(DMAX + 1);
  localparam int CYC_N = 2 * (AZ + INTC + DMAX + ZB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp = 1'b0, rng = 1'b0, hld = 1'b0, pk = 1'b0;
  logic ph_zero, ph_az, ph_int, ph_deint, ref_neg, eoc_n, rd_neg, ovr, udr;
  logic [RW-1:0] rd_bin;
  logic [15:0]   rd_bcd;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_bin = 0;
  logic m_neg = 1'b0;
  int last_az = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dsadc_seq #(
    .CLK_DIV(2), .AZ_COUNTS(AZ), .INT_COUNTS(INTC), .RANGE_DIV(RDIV),
    .FULL_SCALE(FS), .UR_LIMIT(UR), .ZI_BASE(ZB), .EOC_CLKS(EOCC), .DIGITS(4)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_i(cmp), .range_hi_i(rng), .hold_i(hld),
    .peak_hold_i(pk), .ph_zero_o(ph_zero), .ph_az_o(ph_az), .ph_int_o(ph_int),
    .ph_deint_o(ph_deint), .ref_neg_o(ref_neg), .eoc_n_o(eoc_n),
    .rd_bin_o(rd_bin), .rd_bcd_o(rd_bcd), .rd_neg_o(rd_neg), .ovr_o(ovr),
    .udr_o(udr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dec_pack(input int v);
    return ((v / 1000) % 10) * 4096 + ((v / 100) % 10) * 256 +
           ((v / 10) % 10) * 16 + (v % 10);
  endfunction

  // One conversion; flip after k full de-integrate ticks unless tmo.
  task automatic conv(input int k, input logic p, input logic r,
                      input logic h, input logic pkh, input logic tmo);
    int az_n = 0, int_n = 0, low_n = 0, rd;
    rng = r; hld = h; pk = pkh;
    do @(negedge clk); while (!ph_az);
    last_az = cyc;
    cmp = p;
    while (ph_az) begin az_n++; @(negedge clk); end
    while (ph_int) begin int_n++; @(negedge clk); end
    check("R2 nulling clocks", az_n, 2 * AZ);
    check("R3 integrate clocks", int_n, r ? 2 * (INTC / RDIV) : 2 * INTC);
    check("R5 ref select", ref_neg, p);
    if (!tmo) begin
      repeat (2 * k + 1) @(negedge clk);
      cmp = ~p;
    end
    while (ph_deint) @(negedge clk);
    while (eoc_n) @(negedge clk);
    while (!eoc_n) begin low_n++; @(negedge clk); end
    cmp = p;
    check("R9 eoc low clocks", low_n, EOCC);
    rd = tmo ? DMAX : k;
    if (!h && (!pkh || rd > m_bin)) begin
      m_bin = rd;
      m_neg = ~p;
    end
    check("R6 reading", int'(rd_bin), m_bin);
    check("R6 decimal digits", int'(rd_bcd), dec_pack(m_bin));
    check("R5 sign", rd_neg, m_neg);
    check("R7 overrange flag", ovr, m_bin > FS);
    check("R8 underrange flag", udr, m_bin <= UR);
  endtask

  task automatic t_reset;
    check("R1 zero phase", ph_zero, 1);
    check("R1 other phases", {ph_az, ph_int, ph_deint}, 0);
    check("R1 eoc idle", eoc_n, 1);
    check("R1 count", int'(rd_bin), 0);
    check("R1 sign", rd_neg, 0);
    check("R1 overrange", ovr, 0);
    check("R1 underrange", udr, 1);
  endtask

  task automatic t_basic;
    conv(57, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sign_under;
    conv(5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5 negative input sign", rd_neg, 1);
    conv(UR, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 at limit", udr, 1);
    conv(UR + 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 above limit", udr, 0);
  endtask

  task automatic t_over;
    conv(FS, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 at full scale", ovr, 0);
    conv(FS + 1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 above full scale", ovr, 1);
    conv(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R7 timeout reading", int'(rd_bin), DMAX);
    conv(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 immediate flip", int'(rd_bin), 0);
  endtask

  task automatic t_range;
    conv(33, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    conv(33, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_cycle;
    int a1, a2, a3;
    conv(3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);  a1 = last_az;
    conv(80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); a2 = last_az;
    check("R4 cycle after short reading", a2 - a1, CYC_N);
    conv(0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);  a3 = last_az;
    check("R4 cycle after long reading", a3 - a2, CYC_N);
    conv(12, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 cycle after timeout", last_az - a3, CYC_N);
  endtask

  task automatic t_hold;
    conv(20, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    conv(70, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R10 held count", int'(rd_bin), 20);
    check("R10 held sign", rd_neg, 0);
    conv(70, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 released", int'(rd_bin), 70);
  endtask

  task automatic t_peak;
    conv(40, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    conv(60, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 larger magnitude loads", int'(rd_bin), 60);
    check("R11 sign follows", rd_neg, 1);
    conv(30, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 smaller kept", int'(rd_bin), 60);
    conv(60, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R11 equal keeps sign", rd_neg, 1);
    conv(30, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 released", int'(rd_bin), 30);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_basic;
    t_sign_under;
    t_over;
    t_range;
    t_cycle;
    t_hold;
    t_peak;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual %0d expected below %0d", cyc, 100000);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule